// File: doc/BRIEF.md
# Single-Cycle 64-bit Eight-Instruction Core

This block is a 64-bit processor core that runs a fixed set of eight instructions: a load, a store, a branch taken when a register is zero, an unconditional branch, and four register-to-register arithmetic and logic operations. Every instruction is fetched, decoded, executed, given its data memory access and written back in a single clock period. No pipeline is present, so no hazard logic is needed.

The core drives a byte address to an instruction memory and receives a 32-bit instruction word back in the same cycle. A second port carries a byte address, write data and a write strobe to a data memory and receives 64-bit read data combinationally. Any instruction word outside the eight encodings is treated as a no-op: it writes no register, stores nothing, and only moves the program counter on by four.

Top module: `tiny64_core`

## Requirements
- R1: After a synchronous reset is released, the instruction address output is 0.
- R2: Every instruction except the two branches sets the next instruction address to the current one plus 4.
- R3: The R-format word carries its opcode in bits 31..21, the second source in 20..16, the first source in 9..5 and the destination in 4..0. Opcode 10001011000 writes first+second, 11001011000 writes first-second, 10001010000 writes first AND second and 10101010000 writes first OR second. Results are taken modulo 2^64.
- R4: The load (opcode 11111000010 in bits 31..21) writes the 64-bit data memory word read at address base+offset into the register named in bits 4..0. The base register is in bits 9..5 and the signed 9-bit offset is in bits 20..12.
- R5: The store (opcode 11111000000) asserts the write strobe and drives the register named in bits 4..0 as write data. The address uses the same base+offset rule as the load. The write strobe is high on no other instruction.
- R6: The conditional branch (bits 31..24 = 10110100) tests the register in bits 4..0. When that register is zero, the next address is the current address plus the signed 19-bit field in bits 23..5 times 4. Otherwise the next address is the current address plus 4.
- R7: The unconditional branch (bits 31..26 = 000101) sets the next address to the current address plus the signed 26-bit field in bits 25..0 times 4. This covers both negative and maximum positive offsets.
- R8: Register 31 reads as zero whether it is used as a source or as a base, and writes to it are discarded.
- R9: Any other instruction word leaves all registers unchanged and does not write memory.
- R10: A program that uses all eight instructions, with branch loops, reaches the correct final memory contents. The test program is an iterative Fibonacci computation for every count from 0 to 20.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| imemAddr | output | 64 | Byte address of the current instruction |
| imemData | input | 32 | Instruction word at imemAddr |
| dmemAddr | output | 64 | Byte address for the data memory |
| dmemWdata | output | 64 | Store data |
| dmemWe | output | 1 | Store strobe, written on the rising edge |
| dmemRdata | input | 64 | Data memory word at dmemAddr |

## Verification
On every cycle, the assertions check the program counter behaviour that is visible at the ports. They cover the zero address after reset, the plus-4 step for non-branch words, the unconditional branch target, and that the store strobe is raised only while a store word is present. Register contents, arithmetic results, the zero-register rule and the no-op treatment of unknown words are held internally. Only the bench scenarios can show these, by storing registers out to memory after sweeps over pairs of boundary operand values. The conditional branch decision and whole-program behaviour are shown by running the Fibonacci loop for counts 0 to 20 and by short branch-only programs that are checked address by address.

// File: rtl/tiny64_pkg.sv
package tiny64_pkg;

  localparam int REG_AW = 5;

  localparam logic [10:0] OPC_LOAD  = 11'b11111000010;
  localparam logic [10:0] OPC_STORE = 11'b11111000000;
  localparam logic [10:0] OPC_ADD   = 11'b10001011000;
  localparam logic [10:0] OPC_SUB   = 11'b11001011000;
  localparam logic [10:0] OPC_AND   = 11'b10001010000;
  localparam logic [10:0] OPC_ORR   = 11'b10101010000;
  localparam logic [7:0]  OPC_CBZ   = 8'b10110100;
  localparam logic [5:0]  OPC_BR    = 6'b000101;

  typedef enum logic [1:0] {
    ALU_ADD = 2'd0,
    ALU_SUB = 2'd1,
    ALU_AND = 2'd2,
    ALU_ORR = 2'd3
  } aluOp_t;

  typedef struct packed {
    logic   regWrite;
    logic   memToReg;
    logic   memWrite;
    logic   aluSrcImm;
    logic   regBSelRt;
    logic   condBranch;
    logic   uncondBranch;
    aluOp_t aluOp;
  } ctrl_t;

endpackage

// File: rtl/tiny64_regfile.sv
module tiny64_regfile
  import tiny64_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [REG_AW-1:0] rdAddrA,
  input  logic [REG_AW-1:0] rdAddrB,
  output logic [DATA_W-1:0] rdDataA,
  output logic [DATA_W-1:0] rdDataB,
  input  logic              wrEn,
  input  logic [REG_AW-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData
);
  localparam int REG_NUM = 1 << REG_AW;
  localparam logic [REG_AW-1:0] ZERO_REG = REG_AW'(REG_NUM - 1);

  logic [DATA_W-1:0] regs [REG_NUM];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < REG_NUM; i++) regs[i] <= '0;
    end else if (wrEn && (wrAddr != ZERO_REG)) begin
      regs[wrAddr] <= wrData;
    end
  end

  assign rdDataA = (rdAddrA == ZERO_REG) ? '0 : regs[rdAddrA];
  assign rdDataB = (rdAddrB == ZERO_REG) ? '0 : regs[rdAddrB];
endmodule

// File: rtl/tiny64_ctrl.sv
module tiny64_ctrl
  import tiny64_pkg::*;
(
  input  logic [10:0] opcode,
  output ctrl_t       ctrl
);
  always_comb begin
    ctrl       = '0;
    ctrl.aluOp = ALU_ADD;
    if (opcode == OPC_LOAD) begin
      ctrl.regWrite  = 1'b1;
      ctrl.memToReg  = 1'b1;
      ctrl.aluSrcImm = 1'b1;
    end else if (opcode == OPC_STORE) begin
      ctrl.memWrite  = 1'b1;
      ctrl.aluSrcImm = 1'b1;
      ctrl.regBSelRt = 1'b1;
    end else if (opcode == OPC_ADD) begin
      ctrl.regWrite = 1'b1;
    end else if (opcode == OPC_SUB) begin
      ctrl.regWrite = 1'b1;
      ctrl.aluOp    = ALU_SUB;
    end else if (opcode == OPC_AND) begin
      ctrl.regWrite = 1'b1;
      ctrl.aluOp    = ALU_AND;
    end else if (opcode == OPC_ORR) begin
      ctrl.regWrite = 1'b1;
      ctrl.aluOp    = ALU_ORR;
    end else if (opcode[10:3] == OPC_CBZ) begin
      ctrl.condBranch = 1'b1;
      ctrl.regBSelRt  = 1'b1;
    end else if (opcode[10:5] == OPC_BR) begin
      ctrl.uncondBranch = 1'b1;
    end
  end
endmodule

// File: rtl/tiny64_dpath.sv
module tiny64_dpath
  import tiny64_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [25:0]       instrLow,
  input  ctrl_t             ctrl,
  output logic [DATA_W-1:0] pcOut,
  output logic [DATA_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic              memWe,
  input  logic [DATA_W-1:0] memRdata
);
  logic [DATA_W-1:0] pc, pcNext;
  logic [DATA_W-1:0] regA, regB, aluB, aluRes, wbData;
  logic [DATA_W-1:0] memOff, brOff, brTarget;
  logic [REG_AW-1:0] addrB;
  logic              taken;

  assign addrB = ctrl.regBSelRt ? instrLow[4:0] : instrLow[20:16];

  tiny64_regfile #(.DATA_W(DATA_W)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .rdAddrA (instrLow[9:5]),
    .rdAddrB (addrB),
    .rdDataA (regA),
    .rdDataB (regB),
    .wrEn    (ctrl.regWrite),
    .wrAddr  (instrLow[4:0]),
    .wrData  (wbData)
  );

  assign memOff = DATA_W'($signed(instrLow[20:12]));
  assign aluB   = ctrl.aluSrcImm ? memOff : regB;

  always_comb begin
    unique case (ctrl.aluOp)
      ALU_ADD: aluRes = regA + aluB;
      ALU_SUB: aluRes = regA - aluB;
      ALU_AND: aluRes = regA & aluB;
      ALU_ORR: aluRes = regA | aluB;
      default: aluRes = regA + aluB;
    endcase
  end

  assign wbData   = ctrl.memToReg ? memRdata : aluRes;
  assign memAddr  = aluRes;
  assign memWdata = regB;
  assign memWe    = ctrl.memWrite;

  assign brOff    = ctrl.condBranch ? DATA_W'($signed(instrLow[23:5]))
                                    : DATA_W'($signed(instrLow[25:0]));
  assign brTarget = pc + {brOff[DATA_W-3:0], 2'b00};
  assign taken    = ctrl.uncondBranch | (ctrl.condBranch & (regB == '0));
  assign pcNext   = taken ? brTarget : pc + DATA_W'(4);

  always_ff @(posedge clk) begin
    if (rst) pc <= '0;
    else     pc <= pcNext;
  end

  assign pcOut = pc;
endmodule

// File: rtl/tiny64_core.sv
module tiny64_core
  import tiny64_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  output logic [DATA_W-1:0] imemAddr,
  input  logic [31:0]       imemData,
  output logic [DATA_W-1:0] dmemAddr,
  output logic [DATA_W-1:0] dmemWdata,
  output logic              dmemWe,
  input  logic [DATA_W-1:0] dmemRdata
);
  ctrl_t ctrl;

  tiny64_ctrl u_ctrl (
    .opcode (imemData[31:21]),
    .ctrl   (ctrl)
  );

  tiny64_dpath #(.DATA_W(DATA_W)) u_dpath (
    .clk      (clk),
    .rst      (rst),
    .instrLow (imemData[25:0]),
    .ctrl     (ctrl),
    .pcOut    (imemAddr),
    .memAddr  (dmemAddr),
    .memWdata (dmemWdata),
    .memWe    (dmemWe),
    .memRdata (dmemRdata)
  );
endmodule

// File: rtl/tiny64_core_chk.sv
module tiny64_core_chk #(
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rst,
  input logic [DATA_W-1:0] imemAddr,
  input logic [31:0]       imemData,
  input logic              dmemWe
);
  logic isBranch;
  assign isBranch = (imemData[31:26] == 6'b000101) || (imemData[31:24] == 8'b10110100);

  logic [DATA_W-1:0] bJump;
  assign bJump = imemAddr + {DATA_W'($signed(imemData[25:0])) << 2};

  // R1: address is zero on the first cycle after reset
  assert_pc_reset_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (imemAddr == '0));

  // R2: sequential step for non-branch words
  assert_pc_step_R2: assert property (@(posedge clk) disable iff (rst)
    !isBranch |=> (imemAddr == $past(imemAddr) + DATA_W'(4)));

  // R7: unconditional branch target
  assert_br_target_R7: assert property (@(posedge clk) disable iff (rst)
    (imemData[31:26] == 6'b000101) |=> (imemAddr == $past(bJump)));

  // R5, R9: store strobe only with a store word present
  assert_we_store_only_R5: assert property (@(posedge clk) disable iff (rst)
    dmemWe |-> (imemData[31:21] == 11'b11111000000));
endmodule

bind tiny64_core tiny64_core_chk #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .imemAddr (imemAddr),
  .imemData (imemData),
  .dmemWe   (dmemWe)
);

// File: tb/tiny64_core_tb.sv
module tiny64_core_tb;
  localparam int CLK_PERIOD = 10;

  localparam logic [10:0] O_LOAD  = 11'b11111000010;
  localparam logic [10:0] O_STORE = 11'b11111000000;
  localparam logic [10:0] O_ADD   = 11'b10001011000;
  localparam logic [10:0] O_SUB   = 11'b11001011000;
  localparam logic [10:0] O_AND   = 11'b10001010000;
  localparam logic [10:0] O_ORR   = 11'b10101010000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] imemAddr, dmemAddr, dmemWdata, dmemRdata;
  logic [31:0] imemData;
  logic        dmemWe;

  logic [31:0] imem   [64];
  logic [63:0] preset [16];
  logic [63:0] dmem   [16];
  int          weCount = 0;
  int          checks = 0;
  int          failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tiny64_core u_dut (
    .clk(clk), .rst(rst), .imemAddr(imemAddr), .imemData(imemData),
    .dmemAddr(dmemAddr), .dmemWdata(dmemWdata), .dmemWe(dmemWe),
    .dmemRdata(dmemRdata)
  );

  assign imemData  = imem[imemAddr[7:2]];
  assign dmemRdata = dmem[dmemAddr[6:3]];

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 16; i++) dmem[i] <= preset[i];
    end else if (dmemWe) begin
      dmem[dmemAddr[6:3]] <= dmemWdata;
      weCount <= weCount + 1;
    end
  end

  function automatic logic [31:0] encR(logic [10:0] op, int rm, int rn, int rd);
    return {op, rm[4:0], 6'b0, rn[4:0], rd[4:0]};
  endfunction
  function automatic logic [31:0] encD(logic [10:0] op, int off, int rn, int rt);
    return {op, off[8:0], 2'b00, rn[4:0], rt[4:0]};
  endfunction
  function automatic logic [31:0] encCB(int off, int rt);
    return {8'b10110100, off[18:0], rt[4:0]};
  endfunction
  function automatic logic [31:0] encB(int off);
    return {6'b000101, off[25:0]};
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic holdReset();
    @(negedge clk);
    rst = 1'b1;
    for (int i = 0; i < 64; i++) imem[i] = 32'h0;
    for (int i = 0; i < 16; i++) preset[i] = 64'h0;
  endtask

  task automatic release_();
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic step(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  logic [63:0] vals [6];

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    vals[0] = 64'h0;
    vals[1] = 64'h1;
    vals[2] = 64'hFFFF_FFFF_FFFF_FFFF;
    vals[3] = 64'h7FFF_FFFF_FFFF_FFFF;
    vals[4] = 64'h8000_0000_0000_0000;
    vals[5] = 64'h0123_4567_89AB_CDEF;

    // Arithmetic, load/store, zero register and unknown-word sweep
    for (int ia = 0; ia < 6; ia++) begin
      for (int ib = 0; ib < 6; ib++) begin
        int weStart;
        holdReset();
        preset[0] = vals[ia];
        preset[1] = vals[ib];
        preset[6] = 64'hDEAD_BEEF;
        preset[7] = 64'h5555;
        preset[8] = 64'd80;
        imem[0]  = encD(O_LOAD, 0, 31, 1);
        imem[1]  = encD(O_LOAD, 8, 31, 2);
        imem[2]  = encR(O_ADD, 2, 1, 3);
        imem[3]  = encR(O_SUB, 2, 1, 4);
        imem[4]  = encR(O_AND, 2, 1, 5);
        imem[5]  = encR(O_ORR, 2, 1, 6);
        imem[6]  = encD(O_STORE, 16, 31, 3);
        imem[7]  = encD(O_STORE, 24, 31, 4);
        imem[8]  = encD(O_STORE, 32, 31, 5);
        imem[9]  = encD(O_STORE, 40, 31, 6);
        imem[10] = encR(O_ADD, 2, 1, 31);
        imem[11] = encD(O_STORE, 48, 31, 31);
        imem[12] = encR(11'b10001011001, 2, 2, 1);
        imem[13] = encD(O_STORE, 56, 31, 1);
        imem[14] = encD(O_LOAD, 64, 31, 7);
        imem[15] = encD(O_STORE, -8, 7, 2);
        imem[16] = encB(0);
        release_();
        check("R1 reset address", imemAddr, 64'h0);
        weStart = weCount;
        step(1);
        check("R2 step one", imemAddr, 64'h4);
        step(1);
        check("R2 step two", imemAddr, 64'h8);
        step(20);
        check("R7 halt loop address", imemAddr, 64'd64);
        check("R3 add", dmem[2], vals[ia] + vals[ib]);
        check("R3 sub", dmem[3], vals[ia] - vals[ib]);
        check("R3 and", dmem[4], vals[ia] & vals[ib]);
        check("R3 orr", dmem[5], vals[ia] | vals[ib]);
        check("R8 zero register", dmem[6], 64'h0);
        check("R9 unknown word keeps x1", dmem[7], vals[ia]);
        check("R4 negative offset load/store", dmem[9], vals[ib]);
        check("R5 store strobe count", 64'(weCount - weStart), 64'd7);
      end
    end

    // Fibonacci program, counts 0..20
    for (int n = 0; n <= 20; n++) begin
      logic [63:0] fa, fb, ft;
      holdReset();
      preset[0] = 64'(n);
      preset[1] = 64'd1;
      preset[2] = 64'hFFFF;
      imem[0]  = encD(O_LOAD, 0, 31, 1);
      imem[1]  = encD(O_LOAD, 8, 31, 3);
      imem[2]  = encD(O_LOAD, 8, 31, 4);
      imem[3]  = encCB(6, 1);
      imem[4]  = encR(O_ADD, 3, 2, 5);
      imem[5]  = encR(O_ADD, 31, 3, 2);
      imem[6]  = encR(O_ADD, 31, 5, 3);
      imem[7]  = encR(O_SUB, 4, 1, 1);
      imem[8]  = encB(-5);
      imem[9]  = encD(O_STORE, 16, 31, 2);
      imem[10] = encB(0);
      fa = 0; fb = 1;
      for (int k = 0; k < n; k++) begin
        ft = fa + fb; fa = fb; fb = ft;
      end
      release_();
      step(6 * n + 10);
      check("R10 fibonacci result", dmem[2], fa);
      check("R6 loop exit address", imemAddr, 64'd40);
    end

    // Unconditional branch: negative offset and back
    holdReset();
    imem[0]  = encB(-3);
    imem[61] = encB(3);
    release_();
    step(1);
    check("R7 negative offset", imemAddr, 64'hFFFF_FFFF_FFFF_FFF4);
    step(1);
    check("R7 return to zero", imemAddr, 64'h0);

    // Unconditional branch: large and maximum positive offsets
    holdReset();
    imem[0] = encB(26'h0100000);
    release_();
    step(1);
    check("R7 large offset", imemAddr, 64'h40_0000);
    step(1);
    check("R7 large offset again", imemAddr, 64'h80_0000);
    holdReset();
    imem[0] = encB(26'h1FFFFFF);
    release_();
    step(1);
    check("R7 max positive offset", imemAddr, 64'h7FF_FFFC);

    // Conditional branch taken on zero register, negative offset
    holdReset();
    imem[0]  = encCB(-2, 31);
    imem[62] = encCB(2, 31);
    release_();
    step(1);
    check("R6 taken negative", imemAddr, 64'hFFFF_FFFF_FFFF_FFF8);
    step(1);
    check("R6 taken positive", imemAddr, 64'h0);

    // Conditional branch not taken on nonzero register
    holdReset();
    preset[0] = 64'd5;
    imem[0] = encD(O_LOAD, 0, 31, 1);
    imem[1] = encCB(10, 1);
    release_();
    step(2);
    check("R6 not taken", imemAddr, 64'h8);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule